// File: doc/BRIEF.md
# Clocked Serial Receive Controller

This block is a master-mode synchronous serial receiver that sits behind a small register port. Software enables it, programs a clock divider and then reads the data register. That read starts the serial clock. Bytes are shifted in MSB first and each completed byte is moved into the data register, where a "full" flag marks it as unread. Reception keeps running byte after byte until software sets the halt bit. The byte in flight then completes and the clock stops.

An overrun happens when a byte completes while the previous byte is still unread. The old byte is kept, the new one is dropped, and reception freezes. Nothing can start again until software clears the flag with a status read followed by a write. Clearing the enable bit aborts a partial byte at once.

The register port is a plain synchronous one and has no back-pressure. An access is taken in the cycle where `reg_en` is high, and read data appears on `reg_rdata` one clock later. Software is the only consumer of received data. The full and overrun flags provide the flow control: no new byte is ever written over an unread one.

Top module: `sync_rx_ctrl`

## Requirements
- R1: After reset the control register, the status register and the data-full state read 0, the divider reads its reset value (default 1), and `sck_o` is high.
- R2: A read of the data register (address 2) starts reception only when enable (control bit 0) is 1, overrun is 0 and no byte is in flight. With enable 0 the read starts nothing and the serial clock stays high.
- R3: The serial clock idles high. Each bit has a low phase and then a high phase, each lasting DIV+1 system clocks, where DIV is the value in the divider register (address 3). `sdi_i` is sampled on the rising edge, 8 bits per byte, MSB first.
- R4: A completed byte is loaded into the data register and sets the full flag (status bit 0). A read of the data register clears the full flag.
- R5: While enable is 1, reception continues byte after byte. If halt (control bit 1) is 1 when a byte completes, that byte is loaded and the clock stops, with no further falling edges. Busy (status bit 2) is 1 exactly while a byte is in flight.
- R6: When a byte completes while full is 1 and the data register is not being read in that cycle, overrun (status bit 1) is set. The data register keeps the older byte, the new byte is discarded, and reception stops.
- R7: While overrun is 1, a data-register read starts no reception.
- R8: Overrun clears only when a status read that returned overrun = 1 is followed by a status write with bit 1 = 0. A status write without that earlier read leaves overrun at 1.
- R9: Writing enable = 0 in the middle of a byte stops the clock within two cycles and leaves full, overrun and the data register unchanged.
- R10: Register addresses are 0 control, 1 status, 2 data and 3 divider. `reg_rdata` shows the addressed register one clock after the read, and the divider reads back the value written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, one cycle after the read |
| sck_o | output | 1 | Serial clock, idles high |
| sdi_i | input | 1 | Serial data in |

## Verification
The bench sweeps every divider value from 0 to 3 over several byte patterns and measures the low and high phase widths. A design with an off-by-one divider, or one that samples on the wrong edge, shows up as wrong phase widths or shifted bytes.

In a multi-byte run the halt bit is set while the last byte is in flight. The bench counts serial clock edges to catch a design that stops one byte early, stops one byte late, or keeps clocking after the halt.

An overrun is provoked deliberately. A design that overwrites the old byte, keeps running, restarts on a data read, or clears the flag without the status read in between fails this part.

A mid-byte abort is checked for stray clocks and for flags set by the partial byte.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int REG_W  = 8;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    RA_CTRL = 2'd0,
    RA_STAT = 2'd1,
    RA_DATA = 2'd2,
    RA_DIV  = 2'd3
  } srx_addr_e;

  localparam int CB_EN   = 0;
  localparam int CB_HALT = 1;
  localparam int SB_FULL = 0;
  localparam int SB_OVR  = 1;
  localparam int SB_BUSY = 2;
endpackage

// File: rtl/srx_timer.sv
module srx_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half,
  output logic             sck,
  output logic             rise,
  output logic             high_end
);
  logic [DIV_W-1:0] cnt;
  logic             hi_q;
  logic             wrap;

  assign wrap     = run && (cnt == half);
  assign rise     = wrap && !hi_q;
  assign high_end = wrap && hi_q;
  // low phase begins the moment a run starts; idle level is high
  assign sck      = !run || hi_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt  <= '0;
      hi_q <= 1'b0;
    end else if (wrap) begin
      cnt  <= '0;
      hi_q <= ~hi_q;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/srx_shifter.sv
module srx_shifter #(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            rise,
  input  logic            high_end,
  input  logic            sdi,
  output logic [BITS-1:0] word,
  output logic            done
);
  localparam int CNT_W = $clog2(BITS + 1);

  logic [CNT_W-1:0] cnt;
  logic [BITS-1:0]  sh;

  assign word = sh;
  assign done = high_end && (cnt == CNT_W'(BITS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      sh  <= '0;
    end else if (!run) begin
      cnt <= '0;
    end else if (rise) begin
      sh  <= {sh[BITS-2:0], sdi};
      cnt <= cnt + 1'b1;
    end else if (done) begin
      cnt <= '0;
    end
  end
endmodule

// File: rtl/srx_regs.sv
module srx_regs
  import srx_pkg::*;
#(
  parameter int               DIV_W   = 8,
  parameter logic [DIV_W-1:0] DIV_RST = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_en,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              byte_done,
  input  logic [BYTE_W-1:0] rx_word,
  output logic              busy,
  output logic [DIV_W-1:0]  div,
  output logic              en,
  output logic              halt,
  output logic              full,
  output logic              ovr,
  output logic [BYTE_W-1:0] data_q,
  output logic              rd_hit,
  output logic              done_ok
);
  logic armed;
  logic wr, rd, st_rd, ovr_clr, ovr_set, start, stop;
  logic [REG_W-1:0] ctrl_v, stat_v, div_v, rd_v;

  assign wr      = reg_en && reg_we;
  assign rd      = reg_en && !reg_we;
  assign rd_hit  = rd && (reg_addr == RA_DATA);
  assign st_rd   = rd && (reg_addr == RA_STAT);
  assign done_ok = byte_done && en;
  assign ovr_set = done_ok && full && !rd_hit;
  assign ovr_clr = wr && (reg_addr == RA_STAT) && armed && !reg_wdata[SB_OVR];
  assign start   = rd_hit && en && !ovr && !busy;
  assign stop    = done_ok && (halt || ovr_set);

  always_comb begin
    ctrl_v = '0;
    ctrl_v[CB_EN]   = en;
    ctrl_v[CB_HALT] = halt;
    stat_v = '0;
    stat_v[SB_FULL] = full;
    stat_v[SB_OVR]  = ovr;
    stat_v[SB_BUSY] = busy;
    div_v = '0;
    div_v[DIV_W-1:0] = div;
    unique case (srx_addr_e'(reg_addr))
      RA_CTRL: rd_v = ctrl_v;
      RA_STAT: rd_v = stat_v;
      RA_DATA: rd_v = data_q;
      default: rd_v = div_v;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en        <= 1'b0;
      halt      <= 1'b0;
      div       <= DIV_RST;
      data_q    <= '0;
      full      <= 1'b0;
      ovr       <= 1'b0;
      armed     <= 1'b0;
      busy      <= 1'b0;
      reg_rdata <= '0;
    end else begin
      if (wr && reg_addr == RA_CTRL) begin
        en   <= reg_wdata[CB_EN];
        halt <= reg_wdata[CB_HALT];
      end
      if (wr && reg_addr == RA_DIV) div <= reg_wdata[DIV_W-1:0];

      if (done_ok && !ovr_set) begin
        data_q <= rx_word;
        full   <= 1'b1;
      end else if (rd_hit) begin
        full <= 1'b0;
      end

      if (ovr_set)      ovr <= 1'b1;
      else if (ovr_clr) ovr <= 1'b0;

      if (ovr_clr)           armed <= 1'b0;
      else if (st_rd && ovr) armed <= 1'b1;

      if (!en)        busy <= 1'b0;
      else if (stop)  busy <= 1'b0;
      else if (start) busy <= 1'b1;

      if (rd) reg_rdata <= rd_v;
    end
  end
endmodule

// File: rtl/sync_rx_ctrl.sv
module sync_rx_ctrl
  import srx_pkg::*;
#(
  parameter int               DIV_W   = 8,
  parameter logic [DIV_W-1:0] DIV_RST = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_en,
  input  logic             reg_we,
  input  logic [1:0]       reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             sck_o,
  input  logic             sdi_i
);
  logic              busy, en, halt, full, ovr, rd_hit, done_ok;
  logic              rise, high_end, byte_done;
  logic [DIV_W-1:0]  div;
  logic [BYTE_W-1:0] rx_word, data_q;

  srx_regs #(.DIV_W(DIV_W), .DIV_RST(DIV_RST)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .byte_done(byte_done), .rx_word(rx_word),
    .busy(busy), .div(div), .en(en), .halt(halt),
    .full(full), .ovr(ovr), .data_q(data_q),
    .rd_hit(rd_hit), .done_ok(done_ok)
  );

  srx_timer #(.DIV_W(DIV_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(busy), .half(div),
    .sck(sck_o), .rise(rise), .high_end(high_end)
  );

  srx_shifter #(.BITS(BYTE_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .run(busy), .rise(rise),
    .high_end(high_end), .sdi(sdi_i), .word(rx_word), .done(byte_done)
  );
endmodule

// File: rtl/sync_rx_ctrl_chk.sv
module sync_rx_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic       halt,
  input logic       busy,
  input logic       full,
  input logic       ovr,
  input logic       rd_hit,
  input logic       done_ok,
  input logic [7:0] data_q
);
  p_full_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && !done_ok) |=> !full);

  p_halt_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_ok && halt) |=> !busy);

  p_ovr_keeps_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_ok && full && !rd_hit) |=> (ovr && !busy && $stable(data_q)));

  p_no_start_ovr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !busy) |=> !busy);

  p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !busy);
endmodule

bind sync_rx_ctrl sync_rx_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .halt(halt), .busy(busy),
  .full(full), .ovr(ovr), .rd_hit(rd_hit), .done_ok(done_ok),
  .data_q(data_q)
);

// File: tb/sync_rx_ctrl_bench.sv
module sync_rx_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_en = 1'b0, reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       sck_o;
  logic       sdi = 1'b1;

  int checks = 0, errors = 0;
  int nfall = 0, base = 0, seed = 0;
  logic sck_prev = 1'b1;

  sync_rx_ctrl u_sync_rx_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sck_o(sck_o), .sdi_i(sdi)
  );

  always #10 clk = ~clk;

  function automatic logic [7:0] pat(int s, int j);
    return 8'(s * 37 + j * 73 + 5);
  endfunction

  // serial source: next bit presented after every falling edge, MSB first
  always @(negedge clk) begin
    int k;
    logic [7:0] b;
    if (sck_prev && !sck_o) begin
      k = nfall - base;
      b = pat(seed, k / 8);
      sdi <= b[7 - (k % 8)];
      nfall <= nfall + 1;
    end
    sck_prev <= sck_o;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_en = 1'b0; reg_we = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_en = 1'b1; reg_we = 1'b0; reg_addr = a;
    @(negedge clk);
    reg_en = 1'b0;
    d = reg_rdata;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_full(string req);
    logic [7:0] s;
    int tries = 0;
    s = 8'd0;
    while (s[0] == 1'b0 && tries < 400) begin
      rd(2'd1, s);
      tries++;
    end
    chk(req, {31'd0, s[0]}, 32'd1);
  endtask

  initial begin
    #(20 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int n, f0;
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1 / R10: reset values and register map
    chk("R1 sck idle", {31'd0, sck_o}, 32'd1);
    rd(2'd0, d); chk("R1 ctrl", {24'd0, d}, 32'd0);
    rd(2'd1, d); chk("R1 stat", {24'd0, d}, 32'd0);
    rd(2'd3, d); chk("R1 div", {24'd0, d}, 32'd1);
    wr(2'd3, 8'h5A); rd(2'd3, d); chk("R10 div readback", {24'd0, d}, 32'h5A);

    // R2: data read while disabled starts nothing
    rd(2'd2, d);
    idle(20);
    chk("R2 no clocks when disabled", nfall, 0);
    rd(2'd1, d); chk("R2 stat idle", {24'd0, d}, 32'd0);

    // R3 / R4 / R5: single-byte sweep over divider and patterns
    for (int dv = 0; dv < 4; dv++) begin
      for (int s = 0; s < 6; s++) begin
        wr(2'd3, 8'(dv));
        wr(2'd0, 8'h03);
        seed = s * 11 + dv;
        base = nfall;
        rd(2'd2, d);
        n = 0;
        while (sck_o == 1'b0 && n < 100) begin n++; @(negedge clk); end
        chk("R3 low phase width", n, dv + 1);
        n = 0;
        while (sck_o == 1'b1 && n < 100) begin n++; @(negedge clk); end
        chk("R3 high phase width", n, dv + 1);
        wait_full("R4 full set");
        rd(2'd1, d); chk("R5 stopped after halt", {24'd0, d}, 32'd1);
        chk("R5 eight clocks", nfall - base, 8);
        wr(2'd0, 8'h00);
        rd(2'd2, d); chk("R3 R4 byte msb first", {24'd0, d}, {24'd0, pat(seed, 0)});
        rd(2'd1, d); chk("R4 full cleared", {24'd0, d}, 32'd0);
      end
    end

    // R5: continuous run, halt set during the last byte
    wr(2'd3, 8'd1);
    wr(2'd0, 8'h01);
    seed = 9;
    base = nfall;
    rd(2'd2, d);
    for (int k = 0; k < 4; k++) begin
      wait_full("R5 stream full");
      if (k == 3) wr(2'd0, 8'h00);
      rd(2'd2, d);
      chk("R5 stream byte", {24'd0, d}, {24'd0, pat(seed, k)});
      if (k == 2) wr(2'd0, 8'h03);
    end
    idle(60);
    chk("R5 no clocks after halt", nfall - base, 32);
    rd(2'd1, d); chk("R5 stat after halt", {24'd0, d}, 32'd0);

    // R6 / R7 / R8: overrun
    wr(2'd0, 8'h01);
    seed = 21;
    base = nfall;
    rd(2'd2, d);
    idle(150);
    chk("R6 stops at overrun", nfall - base, 16);
    wr(2'd1, 8'h00);
    rd(2'd1, d); chk("R8 no clear without read", {24'd0, d}, 32'd3);
    rd(2'd2, d); chk("R6 old byte kept", {24'd0, d}, {24'd0, pat(21, 0)});
    idle(40);
    rd(2'd1, d); chk("R7 no start on overrun", {24'd0, d}, 32'd2);
    chk("R7 no clocks on overrun", nfall - base, 16);
    wr(2'd1, 8'h00);
    rd(2'd1, d); chk("R8 cleared", {24'd0, d}, 32'd0);

    // R9: abort mid-byte
    wr(2'd3, 8'd2);
    seed = 33;
    base = nfall;
    rd(2'd2, d);
    n = 0;
    while (nfall - base < 3 && n < 300) begin n++; @(negedge clk); end
    wr(2'd0, 8'h00);
    @(negedge clk);
    chk("R9 sck high after abort", {31'd0, sck_o}, 32'd1);
    f0 = nfall;
    rd(2'd1, d); chk("R9 no flags", {24'd0, d}, 32'd0);
    idle(60);
    chk("R9 no clocks after abort", nfall, f0);
    rd(2'd2, d); chk("R9 data unchanged", {24'd0, d}, {24'd0, pat(21, 0)});

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule